// File: doc/BRIEF.md
# SDRAM Burst Data Path with Clock Suspension and Byte-Lane Masking

This block is the controller-side data path for burst reads and writes to a synchronous DRAM. The controller core starts a burst with a direction and a length code. The block then keeps count of which beat is on the bus and asks the core for each beat's write word and mask flag. It drives the clock-enable and data-mask pins and the write data bus with its output enable. On reads, it captures the returning data and marks each beat as usable or masked. Command sequencing, refresh and the pad drivers belong to other blocks.

Everything is counted in bus cycles, meaning the cycles between rising edges of `clk`. Cycle 1 is the cycle after the edge that accepts a burst. A cycle is *live* when `cke` was high in the cycle before it. A cycle that follows a low `cke` is *frozen*: the device's internal clock does not tick, so neither the device nor this block moves the burst forward.

The mask pin has different timing in each direction. A write mask must sit on the bus together with the word it covers. A read mask must be driven two live cycles before the data it hides. The block lines up both cases from the same per-beat mask request.

Top module: `sdram_burst_datapath`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cke`=1, `dqm`=0, `wr_oe`=0, `rd_beat`=0, `rd_valid`=0 and `ready`=1.
- R2: `burst_len` selects the number of beats: code 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. `beat_load` pulses exactly once per beat: in the cycle the burst is accepted, and in each later live cycle that ends a beat other than the last. During a write, `wr_oe` is high until the last beat has been consumed in a live cycle.
- R3: If `suspend_req` is high while the block is busy (a burst or read drain is in progress), `cke` is low in the next cycle. Otherwise `cke` is high in the next cycle. The cycle after a low `cke` is frozen, and no beat advances in it.
- R4: During a write, the word is held on `wr_dq` with `wr_oe` high until a live cycle consumes it. Words are consumed in the order they were loaded.
- R5: During a write, `dqm` is high in exactly the cycles that carry a word whose `mask_req` was high when that word was loaded.
- R6: During a read, the data for beat i is sampled from `rd_dq_in` in the live cycle that comes CAS_LAT live cycles after the cycle in which beat i was issued. `rd_data` shows it with a one-cycle `rd_beat` pulse in the cycle that follows. There is one pulse per beat.
- R7: During a read, a beat loaded with `mask_req` high drives `dqm` high two live cycles before its data cycle. It is still reported with `rd_beat`=1 and `rd_valid`=0. `rd_valid` is never high without `rd_beat`.
- R8: `ready` is low while a burst or read drain is in progress, and while `cke` is low. A `burst_start` given while `ready` is low is ignored and adds no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Request to start a burst; accepted only when `ready` is high |
| burst_write | input | 1 | Direction of the requested burst: 1 write, 0 read |
| burst_len | input | 2 | Length code: 0/1/2/3 gives 1/2/4/8 beats |
| mask_req | input | 1 | Mask flag for the beat being loaded |
| wr_data_in | input | DW | Write word for the beat being loaded |
| suspend_req | input | 1 | Asks for the burst to be frozen (drives `cke` low next cycle) |
| rd_dq_in | input | DW | Data returned from the memory bus |
| ready | output | 1 | A new burst may be started |
| beat_load | output | 1 | The current `mask_req` and `wr_data_in` are taken at the coming edge |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask to the memory |
| wr_dq | output | DW | Write data to the memory bus |
| wr_oe | output | 1 | Output enable for `wr_dq` |
| rd_data | output | DW | Captured read beat |
| rd_beat | output | 1 | One pulse per read beat |
| rd_valid | output | 1 | The captured read beat was not masked |

## Verification
Several relations are checked on every cycle:
- `cke` follows the suspend request, and only while the block is busy.
- Beats load only in live cycles.
- A write word and its mask stay unchanged across a frozen cycle.
- Read beats are captured only in live cycles, and `rd_valid` is never high without `rd_beat`.

Other behaviour only the bench scenarios can show, because it depends on whole sequences: the beat count for each length code, the order of words and masks, the CAS-latency placement of read captures around frozen cycles, and the two-cycle lead of the read mask. A scoreboard compares these against a live-cycle plan that the bench builds from the suspend pattern.

// File: rtl/sdram_dp_pkg.sv
// Shared types for the SDRAM burst data path.
// Assumes bursts of at most 8 beats, so a 3-bit beat index is enough.
package sdram_dp_pkg;

    localparam int unsigned BEAT_W = 3;

    // Burst length codes as seen on the controller request
    typedef enum logic [1:0] {
        BLEN_1 = 2'd0,
        BLEN_2 = 2'd1,
        BLEN_4 = 2'd2,
        BLEN_8 = 2'd3
    } blen_e;

    // One read pipeline slot: a beat is in flight, and whether it is masked
    typedef struct packed {
        logic beat;
        logic mask;
    } rd_slot_t;

    // Index of the final beat for a length code
    function automatic logic [BEAT_W-1:0] final_beat(input blen_e code);
        case (code)
            BLEN_1:  return 3'd0;
            BLEN_2:  return 3'd1;
            BLEN_4:  return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/sdram_dp_seq.sv
// Burst sequencer: accepts a burst, counts beats in live cycles only, and
// drives the clock enable from the suspend request.
// Assumes the caller reports read drain activity through drain_busy, so
// that a suspension can also freeze the read pipeline after the last issue.
module sdram_dp_seq
    import sdram_dp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       start_wr,
    input  logic [1:0] start_len,
    input  logic       suspend_req,
    input  logic       mask_req,
    input  logic       drain_busy,
    output logic       active,
    output logic       is_wr,
    output logic       cur_mask,
    output logic       live,
    output logic       load,
    output logic       cke,
    output logic       ready,
    output logic       busy
);

    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] last_q;
    logic              cke_q;
    logic              cke_d;
    logic              start;
    logic              adv;
    logic              at_last;

    // Decode of accept, advance and the load strobe
    always_comb begin
        busy    = active | drain_busy;
        ready   = !busy && cke_q;
        start   = start_req && ready;
        adv     = active && cke_d;
        at_last = (beat_q == last_q);
        load    = start || (adv && !at_last);
    end

    assign live = cke_d;
    assign cke  = cke_q;

    // Clock-enable pipeline: driven value and the value one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
            cke_d <= 1'b1;
        end else begin
            cke_q <= !(suspend_req && busy);
            cke_d <= cke_q;
        end
    end

    // Beat counter and burst state; frozen cycles leave everything unchanged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            is_wr    <= 1'b0;
            beat_q   <= '0;
            last_q   <= '0;
            cur_mask <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            is_wr    <= start_wr;
            beat_q   <= '0;
            last_q   <= final_beat(blen_e'(start_len));
            cur_mask <= mask_req;
        end else if (adv) begin
            if (at_last) begin
                active   <= 1'b0;
                cur_mask <= 1'b0;
            end else begin
                beat_q   <= beat_q + 3'd1;
                cur_mask <= mask_req;
            end
        end
    end

endmodule

// File: rtl/sdram_dp_wr.sv
// Write side: holds the word for the current beat and applies the write
// mask in the same cycle as the word.
// Assumes load pulses only at beat boundaries, so the word stays on the bus
// through frozen cycles without any extra hold logic.
module sdram_dp_wr #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data_in,
    input  logic          active,
    input  logic          is_wr,
    input  logic          cur_mask,
    output logic [DW-1:0] wr_dq,
    output logic          wr_oe,
    output logic          dqm_wr
);

    logic [DW-1:0] word_q;

    // Word register loaded once per beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= data_in;
        end
    end

    // Bus drive and same-cycle mask while a write burst is open
    always_comb begin
        wr_oe  = active && is_wr;
        wr_dq  = word_q;
        dqm_wr = active && is_wr && cur_mask;
    end

endmodule

// File: rtl/sdram_dp_rd.sv
// Read side: a delay line over live cycles that matches the CAS latency,
// the read mask placed two live cycles ahead of its data, and the capture
// of each beat with a masked/unmasked flag.
// Assumes CL >= 2; the whole line holds still in frozen cycles.
module sdram_dp_rd
    import sdram_dp_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned CL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          issue,
    input  logic          issue_mask,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_beat,
    output logic          rd_valid,
    output logic          dqm_rd,
    output logic          drain_busy
);

    localparam int unsigned MASK_TAP = CL - 2;

    rd_slot_t stg [1:CL];
    rd_slot_t head;
    logic     cap;

    // Slot for the beat on issue in this cycle, and the capture condition
    always_comb begin
        head.beat = issue;
        head.mask = issue_mask;
        cap       = live && stg[CL].beat;
    end

    // Any beat still in flight keeps the path busy
    always_comb begin
        drain_busy = 1'b0;
        for (int s = 1; s <= int'(CL); s++) begin
            drain_busy = drain_busy | stg[s].beat;
        end
    end

    // Delay line shifting only in live cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 1; s <= int'(CL); s++) begin
                stg[s] <= '0;
            end
        end else if (live) begin
            stg[1] <= head;
            for (int s = 2; s <= int'(CL); s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    // Capture of the returning beat and its flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_beat  <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_beat  <= cap;
            rd_valid <= cap && !stg[CL].mask;
            if (cap) begin
                rd_data <= dq_in;
            end
        end
    end

    // Mask tap: two live cycles ahead of the data slot
    generate
        if (CL == 2) begin : g_tap_issue
            assign dqm_rd = head.beat && head.mask;
        end else begin : g_tap_line
            assign dqm_rd = stg[MASK_TAP].beat && stg[MASK_TAP].mask;
        end
    endgenerate

endmodule

// File: rtl/sdram_burst_datapath.sv
// Top of the SDRAM burst data path. It ties the sequencer to the write and
// read sides and merges their masks onto the single mask pin.
// Assumes the controller core issues the matching command itself in the
// cycle after burst_start is accepted.
module sdram_burst_datapath #(
    parameter int unsigned DW      = 16,
    parameter int unsigned CAS_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_start,
    input  logic          burst_write,
    input  logic [1:0]    burst_len,
    input  logic          mask_req,
    input  logic [DW-1:0] wr_data_in,
    input  logic          suspend_req,
    input  logic [DW-1:0] rd_dq_in,
    output logic          ready,
    output logic          beat_load,
    output logic          cke,
    output logic          dqm,
    output logic [DW-1:0] wr_dq,
    output logic          wr_oe,
    output logic [DW-1:0] rd_data,
    output logic          rd_beat,
    output logic          rd_valid
);

    logic active;
    logic is_wr;
    logic cur_mask;
    logic live;
    logic busy;
    logic drain_busy;
    logic dqm_wr;
    logic dqm_rd;

    sdram_dp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (burst_start),
        .start_wr   (burst_write),
        .start_len  (burst_len),
        .suspend_req(suspend_req),
        .mask_req   (mask_req),
        .drain_busy (drain_busy),
        .active     (active),
        .is_wr      (is_wr),
        .cur_mask   (cur_mask),
        .live       (live),
        .load       (beat_load),
        .cke        (cke),
        .ready      (ready),
        .busy       (busy)
    );

    sdram_dp_wr #(.DW(DW)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (beat_load),
        .data_in (wr_data_in),
        .active  (active),
        .is_wr   (is_wr),
        .cur_mask(cur_mask),
        .wr_dq   (wr_dq),
        .wr_oe   (wr_oe),
        .dqm_wr  (dqm_wr)
    );

    sdram_dp_rd #(.DW(DW), .CL(CAS_LAT)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .issue     (active && !is_wr),
        .issue_mask(cur_mask),
        .dq_in     (rd_dq_in),
        .rd_data   (rd_data),
        .rd_beat   (rd_beat),
        .rd_valid  (rd_valid),
        .dqm_rd    (dqm_rd),
        .drain_busy(drain_busy)
    );

    // One pin carries both uses of the mask
    assign dqm = dqm_wr | dqm_rd;

endmodule

// File: rtl/sdram_burst_datapath_chk.sv
// Property checker for the SDRAM burst data path, attached by bind.
// It watches the ports plus the internal busy flag.
module sdram_burst_datapath_chk #(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          suspend_req,
    input logic          busy,
    input logic          cke,
    input logic          dqm,
    input logic          wr_oe,
    input logic [DW-1:0] wr_dq,
    input logic          rd_beat,
    input logic          rd_valid,
    input logic          beat_load,
    input logic          ready
);

    // R3: a suspend while busy lowers the clock enable in the next cycle
    a_r3_cke_low_on_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_req && busy) |=> !cke);

    // R3: without a suspend request the clock enable is high in the next cycle
    a_r3_cke_high_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend_req |=> cke);

    // R4 and R5: a write word and its mask survive a frozen cycle unchanged
    a_r4_word_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_oe && !$past(cke)) |=> (wr_oe && $stable(wr_dq) && $stable(dqm)));

    // R2: after acceptance, beats load only in live cycles
    a_r2_load_only_live: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_load && !ready) |-> $past(cke));

    // R8: no new burst is possible while the write bus is driven
    a_r8_busy_during_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe |-> !ready);

    // R6: read beats are captured only at the end of live cycles
    a_r6_capture_live: assert property (@(posedge clk) disable iff (!rst_n)
        rd_beat |-> $past(cke, 2));

    // R7: a valid flag always sits on a beat strobe
    a_r7_valid_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_beat);

endmodule

bind sdram_burst_datapath sdram_burst_datapath_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .suspend_req(suspend_req),
    .busy       (busy),
    .cke        (cke),
    .dqm        (dqm),
    .wr_oe      (wr_oe),
    .wr_dq      (wr_dq),
    .rd_beat    (rd_beat),
    .rd_valid   (rd_valid),
    .beat_load  (beat_load),
    .ready      (ready)
);

// File: tb/tb_sdram_burst_datapath.sv
// Scoreboard bench: the burst driver works out the live-cycle plan from its
// suspend pattern and queues the expected beats; a monitor pops and compares.
module tb_sdram_burst_datapath;

    localparam int unsigned DW = 16;
    localparam int          CL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          burst_start = 1'b0;
    logic          burst_write = 1'b0;
    logic [1:0]    burst_len = 2'd0;
    logic          mask_req = 1'b0;
    logic [DW-1:0] wr_data_in = '0;
    logic          suspend_req = 1'b0;
    logic [DW-1:0] rd_dq_in = '0;
    logic          ready, beat_load, cke, dqm, wr_oe, rd_beat, rd_valid;
    logic [DW-1:0] wr_dq, rd_data;

    int n_checks = 0;
    int n_errs   = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    logic [DW:0] wq[$];
    logic [DW:0] rq[$];

    always #2 clk = ~clk;

    sdram_burst_datapath #(.DW(DW), .CAS_LAT(CL)) dut (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
        .burst_write(burst_write), .burst_len(burst_len), .mask_req(mask_req),
        .wr_data_in(wr_data_in), .suspend_req(suspend_req), .rd_dq_in(rd_dq_in),
        .ready(ready), .beat_load(beat_load), .cke(cke), .dqm(dqm),
        .wr_dq(wr_dq), .wr_oe(wr_oe), .rd_data(rd_data), .rd_beat(rd_beat),
        .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rdpat(input int c);
        return {8'hC0, 8'(c)};
    endfunction

    // Monitor: consumes write beats in live cycles and read beats on strobes
    logic          prev_cke = 1'b1;
    logic          frz_oe_prev = 1'b0;
    logic [DW-1:0] last_dq = '0;
    logic          last_dqm = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            logic [DW:0] e;
            if (frz_oe_prev)
                check(wr_oe && wr_dq == last_dq && dqm == last_dqm, "R4",
                      "word held after frozen cycle", {wr_oe, dqm, wr_dq}, {1'b1, last_dqm, last_dq});
            if (wr_oe && prev_cke) begin
                if (wq.size() == 0) check(1'b0, "R2", "extra write beat", wr_dq, 0);
                else begin
                    e = wq.pop_front();
                    check(wr_dq == e[DW-1:0], "R4", "write word order", wr_dq, e[DW-1:0]);
                    check(dqm == e[DW], "R5", "write mask same cycle", dqm, e[DW]);
                end
            end
            if (rd_valid && !rd_beat) check(1'b0, "R7", "valid without beat", rd_valid, 0);
            if (rd_beat) begin
                if (rq.size() == 0) check(1'b0, "R6", "extra read beat", rd_data, 0);
                else begin
                    e = rq.pop_front();
                    check(rd_data == e[DW-1:0], "R6", "read data slot", rd_data, e[DW-1:0]);
                    check(rd_valid == e[DW], "R7", "read valid flag", rd_valid, e[DW]);
                end
            end
            frz_oe_prev = wr_oe && !prev_cke;
            last_dq     = wr_dq;
            last_dqm    = dqm;
            prev_cke    = cke;
        end
    end

    // Driver: plans live cycles from the suspend pattern, queues expectations, runs the burst
    task automatic run_burst(input bit wr, input logic [1:0] code, input logic [7:0] masks,
                             input logic [63:0] susp, input int retrig, input logic [DW-1:0] seed);
        int  n = 1 << code;
        bit  ckem [0:63];
        int  lv [0:63];
        int  nl = 0;
        int  k = 0;
        int  loads = 0;
        bit  ld = 1'b0;
        ckem[0] = 1'b1;
        for (int c = 0; c < 63; c++) ckem[c+1] = !susp[c];
        for (int c = 1; c < 64; c++) if (ckem[c-1]) begin lv[nl] = c; nl++; end
        for (int i = 0; i < n; i++) begin
            if (wr) wq.push_back({masks[i], seed + DW'(i)});
            else    rq.push_back({!masks[i], rdpat(lv[i+CL])});
        end
        @(negedge clk);
        while (!ready) @(negedge clk);
        for (int c = 0; c < 48; c++) begin
            if (c > 0) @(negedge clk);
            if (c > 0 && ld) k++;
            if (c >= 1) check(cke == ckem[c], "R3", "clock enable plan", cke, ckem[c]);
            if (!wr)
                for (int i = 0; i < n; i++)
                    if (lv[i+CL-2] == c) check(dqm == masks[i], "R7", "read mask lead", dqm, masks[i]);
            if (c == retrig) check(!ready, "R8", "ready low while busy", ready, 0);
            burst_start = (c == 0) || (c == retrig);
            burst_write = wr;
            burst_len   = code;
            mask_req    = (k < 8) ? masks[k] : 1'b0;
            wr_data_in  = seed + DW'(k);
            suspend_req = susp[c];
            rd_dq_in    = rdpat(c);
            #1;
            ld = beat_load;
            if (ld) loads++;
        end
        @(negedge clk);
        burst_start = 1'b0;
        suspend_req = 1'b0;
        check(loads == n, "R2", "beat loads per burst", loads, n);
        check(wq.size() == 0, "R2", "write beats left", wq.size(), 0);
        check(rq.size() == 0, "R6", "read beats left", rq.size(), 0);
        check(ready, "R8", "ready after burst", ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cke && !dqm && !wr_oe && !rd_beat && !rd_valid && ready, "R1", "outputs in reset",
              {cke, dqm, wr_oe, rd_beat, rd_valid, ready}, 6'b100001);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke && !dqm && !wr_oe && !rd_beat && !rd_valid && ready, "R1", "outputs after reset",
              {cke, dqm, wr_oe, rd_beat, rd_valid, ready}, 6'b100001);
        mon_en = 1'b1;
        // R3: suspend while idle leaves the clock enable high
        suspend_req = 1'b1;
        repeat (2) @(negedge clk);
        check(cke && ready, "R3", "idle suspend ignored", {cke, ready}, 2'b11);
        suspend_req = 1'b0;
        // R2/R5: four-beat write, one masked beat
        run_burst(1'b1, 2'd2, 8'b0000_0100, 64'h0, -1, 16'h5100);
        // R4: eight-beat write frozen for two cycles
        run_burst(1'b1, 2'd3, 8'b1000_0001, 64'h0C, -1, 16'h5200);
        // R2: single-beat masked write
        run_burst(1'b1, 2'd0, 8'b0000_0001, 64'h0, -1, 16'h5300);
        // R6/R7: four-beat read, one masked beat
        run_burst(1'b0, 2'd2, 8'b0000_0010, 64'h0, -1, 16'h0);
        // R3/R6: eight-beat read frozen during issue and during drain
        run_burst(1'b0, 2'd3, 8'b0101_0000, 64'h210, -1, 16'h0);
        // R8: two-beat read with a second start while busy
        run_burst(1'b0, 2'd1, 8'b0000_0000, 64'h0, 2, 16'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule